// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is a two-wire serial bus slave that holds the six 8-bit configuration bytes of a clock generator and presents them as one parallel vector to the output-enable and frequency-select logic around it. Its bus address pair is hard-wired. It has no sub-addressing: every write fills the registers in order from byte 0, and every read returns the whole register set, starting with a byte count.

A write transaction sends the write address, then a command byte and a count byte, then data. The slave acknowledges the command and count bytes and throws their values away. Each data byte goes into the next register. The host may stop after any complete byte, and the registers it did not reach keep their values. A read transaction sends the read address. The slave then returns the count followed by the registers, for as long as the host keeps acknowledging.

SCL and SDA are sampled on a system clock through two-flop synchronizers. That clock must run at least eight times faster than SCL. START and STOP are recognised as an SDA edge while SCL is high. The slave only ever pulls SDA low, through `sda_oe_o`.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read). For any other address byte it leaves SDA released and ignores the bus until the next START.
- R2: In a write, the slave acknowledges the first two bytes after the address and discards their values. No register changes because of them.
- R3: In a write, data bytes load register 0, 1, 2 and so on in order. The slave acknowledges each byte by holding SDA low through the ninth SCL pulse.
- R4: A STOP after any complete data byte ends the write. Registers the write did not reach keep their previous values.
- R5: Data bytes after the sixth in one write are acknowledged and have no effect on any register.
- R6: In a read, the slave first sends the count 0x06 and then registers 0 to 5. Each byte is sent MSB first, and SDA changes only while SCL is low.
- R7: While the host keeps acknowledging past register 5, the slave sends 0xFF. A host NACK ends the read and leaves SDA released.
- R8: After reset, register 0 is 0x00 and registers 1 to 5 are 0xFF. Register k appears on `cfg_o[8k+7:8k]`.
- R9: A repeated START at any point restarts the framing at the address byte, so a write may be followed directly by a read or by a fresh write.
- R10: `sda_oe_o` is low in idle. It changes only after an SCL falling edge or a bus condition, and never while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cfg_o | output | 48 | Register k on bits [8k+7:8k] |

## Verification
The hardest state to reach is a transfer that is cut off or redirected partway through: a repeated START right after the command byte, a STOP after two data bytes, or a host that keeps acknowledging past the last register. Directed host tasks build each of these framings bit by bit on a wired-AND SDA line. The bench then reads the resulting register vector, and the acknowledge and data bits the slave drove, against its own model of the registers. A monitor confirms for the whole run that the slave's drive never moves while SCL is high.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_RDNXT
  } link_state_e;
endpackage

// File: rtl/clkcfg_bus_sampler.sv
module clkcfg_bus_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_o;
      sda_d  <= sda_o;
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // bus conditions: SDA edge while SCL held high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

  p_cond_scl_high_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> $past(scl_o))
    else $error("bus condition seen without SCL high");
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
  parameter int unsigned          NUM_REGS  = 6,
  parameter int unsigned          IDX_W     = 4,
  parameter logic [8*NUM_REGS-1:0] DEFAULTS = '0,
  parameter logic [7:0]           FILL_BYTE = 8'hFF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= DEFAULTS[8*g +: 8];
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     regs_q[g] <= wr_data_i;
    end
    assign cfg_o[8*g +: 8] = regs_q[g];
  end

  // out-of-range read index returns the fill byte
  always_comb begin
    rd_data_o = FILL_BYTE;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs_q[i];
  end

  p_hold_without_write_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o))
    else $error("register changed without a write strobe");
endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned PTR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);
  localparam logic [PTR_W-1:0] PTR_MAX    = PTR_W'(NUM_REGS + 2);
  localparam logic [PTR_W-1:0] DATA_FIRST = PTR_W'(2);
  localparam logic [7:0]       COUNT_BYTE = 8'(NUM_REGS);

  link_state_e      state_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q, tx_q, tx_byte;
  logic [PTR_W-1:0] ptr_q, ptr_inc;
  logic             addr_phase_q, rd_mode_q, sda_oe_q;
  logic             wr_en_q;
  logic [PTR_W-1:0] wr_idx_q;
  logic [7:0]       wr_data_q;

  assign ptr_inc  = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 1'b1;
  assign rd_idx_o = ptr_q - 1'b1;
  assign tx_byte  = (ptr_q == '0) ? COUNT_BYTE : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      bit_cnt_q    <= '0;
      shreg_q      <= '0;
      tx_q         <= '0;
      ptr_q        <= '0;
      addr_phase_q <= 1'b0;
      rd_mode_q    <= 1'b0;
      sda_oe_q     <= 1'b0;
      wr_en_q      <= 1'b0;
      wr_idx_q     <= '0;
      wr_data_q    <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q      <= ST_RX;
        bit_cnt_q    <= '0;
        addr_phase_q <= 1'b1;
        rd_mode_q    <= 1'b0;
        sda_oe_q     <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              if (addr_phase_q) begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  addr_phase_q <= 1'b0;
                  rd_mode_q    <= shreg_q[0];
                  ptr_q        <= '0;
                  sda_oe_q     <= 1'b1;
                  state_q      <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                // header bytes and overrun bytes are acked but not stored
                if (ptr_q >= DATA_FIRST && ptr_q < PTR_MAX) begin
                  wr_en_q   <= 1'b1;
                  wr_idx_q  <= ptr_q - DATA_FIRST;
                  wr_data_q <= shreg_q;
                end
                ptr_q    <= ptr_inc;
                sda_oe_q <= 1'b1;
                state_q  <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (rd_mode_q) begin
                tx_q      <= tx_byte;
                sda_oe_q  <= ~tx_byte[7];
                bit_cnt_q <= 4'd1;
                state_q   <= ST_TX;
              end else begin
                sda_oe_q  <= 1'b0;
                bit_cnt_q <= '0;
                state_q   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_MACK;
              end else begin
                sda_oe_q  <= ~tx_q[6];
                tx_q      <= {tx_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              if (!sda_i) begin
                ptr_q   <= ptr_inc;
                state_q <= ST_RDNXT;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_RDNXT: begin
            if (scl_fall_i) begin
              tx_q      <= tx_byte;
              sda_oe_q  <= ~tx_byte[7];
              bit_cnt_q <= 4'd1;
              state_q   <= ST_TX;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;

  p_drive_on_fall_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_q) |-> $past(scl_fall_i || start_i || stop_i))
    else $error("SDA drive changed outside an SCL low phase");

  p_ack_slot_low_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACK |-> sda_oe_q)
    else $error("ack slot without SDA pulled low");

  p_store_only_write_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> (!rd_mode_q && $past(ptr_q) >= DATA_FIRST))
    else $error("register store outside the data phase of a write");

  p_nack_releases_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MACK && scl_rise_i && sda_i && !start_i && !stop_i)
      |=> (state_q == ST_IDLE && !sda_oe_q))
    else $error("host NACK did not end the read");
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int unsigned           NUM_REGS    = 6,
  parameter logic [6:0]            DEV_ADDR    = 7'h69,
  parameter logic [8*NUM_REGS-1:0] DEFAULTS    = 48'hFFFF_FFFF_FF00,
  parameter logic [7:0]            FILL_BYTE   = 8'hFF,
  parameter int unsigned           SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  localparam int unsigned PTR_W = $clog2(NUM_REGS + 3);

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic wr_en;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  clkcfg_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  clkcfg_link #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_link (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c),
    .rd_data_i(rd_data), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .sda_oe_o
  );

  clkcfg_regfile #(
    .NUM_REGS(NUM_REGS), .IDX_W(PTR_W), .DEFAULTS(DEFAULTS), .FILL_BYTE(FILL_BYTE)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .cfg_o
  );

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
`timescale 1ns/1ps
module clkcfg_i2c_slave_bench;
  localparam int Q = 10;  // system clocks per SCL quarter period

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [47:0] cfg;
  wire sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0, r10_viol = 0;
  logic [7:0] model [6];
  logic done = 1'b0;

  always #4 clk = ~clk;

  clkcfg_i2c_slave u_clkcfg_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  // R10 monitor: slave drive must hold while SCL stays high
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && sda_oe !== oe_prev) r10_viol++;
    scl_prev <= scl;
    oe_prev  <= sda_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    end
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); ack = ~sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic rbyte(input logic host_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0; qw();
    end
    m_sda = ~host_ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    m_sda = 1'b1;
  endtask

  function automatic logic [47:0] model_vec();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[8*k +: 8] = model[k];
    return v;
  endfunction

  task automatic t_reset();
    model[0] = 8'h00;
    for (int k = 1; k < 6; k++) model[k] = 8'hFF;
    chk("R8 reset defaults", cfg, model_vec());
    chk("R10 idle release", sda_oe, 1'b0);
  endtask

  task automatic t_full_write();
    logic a;
    bus_start();
    wbyte(8'hD2, a); chk("R1 write address ack", a, 1'b1);
    wbyte(8'h5A, a); chk("R2 command ack", a, 1'b1);
    wbyte(8'h03, a); chk("R2 count ack", a, 1'b1);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d = 8'h11 * 8'(k + 1);
      wbyte(d, a); chk("R3 data ack", a, 1'b1);
      model[k] = d;
    end
    bus_stop();
    chk("R3 R2 sequential load, header discarded", cfg, model_vec());
  endtask

  task automatic t_read_all();
    logic a; logic [7:0] b;
    bus_start();
    wbyte(8'hD3, a); chk("R1 read address ack", a, 1'b1);
    rbyte(1'b1, b); chk("R6 byte count", b, 8'h06);
    for (int k = 0; k < 6; k++) begin
      rbyte(1'b1, b); chk("R6 readback", b, model[k]);
    end
    rbyte(1'b1, b); chk("R7 fill after last register", b, 8'hFF);
    rbyte(1'b0, b); chk("R7 fill before nack", b, 8'hFF);
    chk("R7 released after nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  task automatic t_partial();
    logic a;
    bus_start();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h06, a);
    wbyte(8'hA1, a); wbyte(8'hB2, a); chk("R4 last byte ack", a, 1'b1);
    bus_stop();
    model[0] = 8'hA1; model[1] = 8'hB2;
    chk("R4 early stop keeps rest", cfg, model_vec());
  endtask

  task automatic t_overrun();
    logic a; int acks = 0;
    bus_start();
    wbyte(8'hD2, a); wbyte(8'hC3, a); wbyte(8'hFF, a);
    for (int k = 0; k < 9; k++) begin
      wbyte(8'h40 + 8'(k), a);
      if (k < 6) model[k] = 8'h40 + 8'(k);
      if (a) acks++;
    end
    bus_stop();
    chk("R5 overrun bytes acked", acks, 9);
    chk("R5 overrun bytes ignored", cfg, model_vec());
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    wbyte(8'hA4, a); chk("R1 foreign address not acked", a, 1'b0);
    wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h77, a);
    chk("R1 bus ignored after foreign address", a, 1'b0);
    bus_stop();
    chk("R1 registers untouched", cfg, model_vec());
  endtask

  task automatic t_restart();
    logic a; logic [7:0] b;
    bus_start();
    wbyte(8'hD2, a); wbyte(8'h12, a);
    bus_start();
    wbyte(8'hD3, a); chk("R9 read address after restart", a, 1'b1);
    rbyte(1'b1, b); chk("R9 count after restart", b, 8'h06);
    rbyte(1'b0, b); chk("R9 reg0 after restart", b, model[0]);
    bus_start();
    wbyte(8'hD2, a); wbyte(8'h00, a);
    bus_start();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h06, a); wbyte(8'h9C, a);
    bus_stop();
    model[0] = 8'h9C;
    chk("R9 fresh write after restart", cfg, model_vec());
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    qw();
    t_reset();
    t_full_write();
    t_read_all();
    t_partial();
    t_overrun();
    t_bad_addr();
    t_restart();
    chk("R10 drive stable while SCL high", r10_viol, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule